// File: doc/BRIEF.md
# Power-Gating Sequence Controller

This controller lives in the always-on domain and walks a switchable core supply through a safe shutdown and a safe restart. A sleep request starts the shutdown. The controller first clamps the crossings between the domains. It then parks external DRAM in self-refresh, and only after that does it drop the supply-enable line to the regulator. A wake event arrives asynchronously and is synchronised before use. It raises supply-enable again and waits for the supply to be good. That condition comes either from the regulator's power-good input or from a programmable ramp counter, for regulators that lack that signal. The controller then holds for a programmable settling time, releases self-refresh and isolation together, and reports ready.

The settling time has a floor equal to 100 µs at the configured clock rate. Any value written below that floor is raised to it. A core clock ratio can be staged at any time and is applied at the moment power is restored. If power-good does not arrive within a bounded number of cycles, a timeout flag is raised. A wake that lands while the shutdown is still under way aborts it before the supply is touched.

Top module: `pgate_seq_ctrl`

## Requirements
- R1: After reset the controller is running: pwr_en_o=1, iso_en_o=0, self_refresh_o=0, ready_o=1, pgood_timeout_o=0, core_ratio_o=RATIO_RST, and the settling register holds the floor value.
- R2: A sleep_req_i sampled high while running moves one step per clock edge. The first edge raises isolation and drops ready. The next edge raises self-refresh. The edge after that drops pwr_en_o.
- R3: pwr_en_o is low only while both iso_en_o and self_refresh_o are high.
- R4: wake_async_i passes two synchroniser flops. With the supply off, pwr_en_o rises on the third rising edge after the wake input goes high.
- R5: With use_ramp_cnt_i=0, the controller waits with the supply on for a sampled pwr_ok_i=1 before starting to settle. ready_o never rises while pwr_ok_i is low.
- R6: With use_ramp_cnt_i=1, the wait lasts exactly ramp_cycles_i+1 cycles and pwr_ok_i is ignored.
- R7: Settling lasts the stored settling value plus one cycle. A write through stab_we_i below CLK_MHZ*MIN_STAB_US stores that floor instead.
- R8: After settling, one cycle has isolation and self-refresh released with ready low. The next cycle has ready_o high, and the controller then stays running.
- R9: A synchronised wake seen in the isolation or self-refresh step aborts the shutdown. pwr_en_o never falls, and the controller goes through the release and ready steps.
- R10: A ratio written through ratio_we_i is only staged. core_ratio_o takes it on the edge where pwr_en_o rises after a power-off. An aborted shutdown leaves core_ratio_o unchanged.
- R11: With use_ramp_cnt_i=0, pgood_timeout_o is high from the (PGOOD_TMO+1)-th wait cycle until the wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to power down the core domain |
| wake_async_i | input | 1 | Asynchronous wake event (level) |
| pwr_ok_i | input | 1 | Regulator power-good |
| use_ramp_cnt_i | input | 1 | 1: ramp counter replaces power-good |
| ramp_cycles_i | input | RAMP_W | Ramp counter load value |
| stab_we_i | input | 1 | Write strobe for settling time |
| stab_cycles_i | input | STAB_W | Settling time in cycles |
| ratio_we_i | input | 1 | Write strobe for staged core ratio |
| ratio_i | input | RATIO_W | Core ratio to apply on next wake |
| pwr_en_o | output | 1 | Supply enable to regulator |
| iso_en_o | output | 1 | Isolation enable on domain crossings |
| self_refresh_o | output | 1 | DRAM self-refresh request |
| ready_o | output | 1 | Core domain powered and usable |
| core_ratio_o | output | RATIO_W | Core clock ratio in effect |
| pgood_timeout_o | output | 1 | Power-good wait timed out |

## Verification
The bench builds the block with CLK_MHZ=2 and MIN_STAB_US=4, which gives a floor of 8 cycles. It uses 6-bit settling, ramp and timeout counters, PGOOD_TMO=20, and 4-bit ratios. With these values, the floor clamp, the exact settling and ramp window lengths, and the power-good timeout each show up within a few dozen cycles. The same bench also covers the aborted shutdown and staged ratios that are applied, and ones that are not applied.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_ISO_ON    = 3'd1,
    ST_SELF_REF  = 3'd2,
    ST_POWER_OFF = 3'd3,
    ST_WAIT_PG   = 3'd4,
    ST_STABILISE = 3'd5,
    ST_ISO_OFF   = 3'd6,
    ST_READY     = 3'd7
  } pg_state_e;
endpackage

// File: rtl/pgate_sync.sv
module pgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pgate_timer.sv
module pgate_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgate_cfg.sv
module pgate_cfg #(
  parameter int STAB_W    = 16,
  parameter int RATIO_W   = 6,
  parameter int MIN_STAB  = 20000,
  parameter int RATIO_RST = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stab_we_i,
  input  logic [STAB_W-1:0]  stab_val_i,
  input  logic               ratio_we_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [STAB_W-1:0]  stab_o,
  output logic [RATIO_W-1:0] pend_ratio_o
);
  localparam logic [STAB_W-1:0]  FLOOR = STAB_W'(MIN_STAB);
  localparam logic [RATIO_W-1:0] R_RST = RATIO_W'(RATIO_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_o       <= FLOOR;
      pend_ratio_o <= R_RST;
    end else begin
      if (stab_we_i)  stab_o       <= (stab_val_i < FLOOR) ? FLOOR : stab_val_i;
      if (ratio_we_i) pend_ratio_o <= ratio_i;
    end
  end
endmodule

// File: rtl/pgate_seq_ctrl.sv
module pgate_seq_ctrl
  import pgate_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int MIN_STAB_US = 100,
  parameter int STAB_W      = 16,
  parameter int RAMP_W      = 16,
  parameter int TMO_W       = 16,
  parameter int PGOOD_TMO   = 50000,
  parameter int RATIO_W     = 6,
  parameter int RATIO_RST   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               wake_async_i,
  input  logic               pwr_ok_i,
  input  logic               use_ramp_cnt_i,
  input  logic [RAMP_W-1:0]  ramp_cycles_i,
  input  logic               stab_we_i,
  input  logic [STAB_W-1:0]  stab_cycles_i,
  input  logic               ratio_we_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               pwr_en_o,
  output logic               iso_en_o,
  output logic               self_refresh_o,
  output logic               ready_o,
  output logic [RATIO_W-1:0] core_ratio_o,
  output logic               pgood_timeout_o
);
  localparam int MIN_STAB = CLK_MHZ * MIN_STAB_US;
  localparam int SEQ_W    = (STAB_W > RAMP_W) ? STAB_W : RAMP_W;

  pg_state_e          st_q, st_d;
  logic               wake_s;
  logic [STAB_W-1:0]  stab_q;
  logic [RATIO_W-1:0] pend_ratio;
  logic               seq_zero, tmo_zero;
  logic               wake_go, pg_go, seq_load, seq_dec;
  logic [SEQ_W-1:0]   seq_val;

  pgate_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_async_i), .q_o(wake_s)
  );

  pgate_cfg #(
    .STAB_W(STAB_W), .RATIO_W(RATIO_W), .MIN_STAB(MIN_STAB), .RATIO_RST(RATIO_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stab_we_i(stab_we_i), .stab_val_i(stab_cycles_i),
    .ratio_we_i(ratio_we_i), .ratio_i(ratio_i),
    .stab_o(stab_q), .pend_ratio_o(pend_ratio)
  );

  assign wake_go  = (st_q == ST_POWER_OFF) && wake_s;
  assign pg_go    = (st_q == ST_WAIT_PG) && (use_ramp_cnt_i ? seq_zero : pwr_ok_i);
  assign seq_load = wake_go || pg_go;
  assign seq_val  = wake_go ? SEQ_W'(ramp_cycles_i) : SEQ_W'(stab_q);
  assign seq_dec  = (st_q == ST_WAIT_PG) || (st_q == ST_STABILISE);

  // one counter serves the ramp wait and then the settling time
  pgate_timer #(.W(SEQ_W)) u_seq_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(seq_load), .load_val_i(seq_val),
    .dec_i(seq_dec), .zero_o(seq_zero)
  );

  pgate_timer #(.W(TMO_W)) u_tmo_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wake_go), .load_val_i(TMO_W'(PGOOD_TMO)),
    .dec_i(st_q == ST_WAIT_PG), .zero_o(tmo_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:       if (sleep_req_i) st_d = ST_ISO_ON;
      ST_ISO_ON:    st_d = wake_s ? ST_ISO_OFF : ST_SELF_REF;
      ST_SELF_REF:  st_d = wake_s ? ST_ISO_OFF : ST_POWER_OFF;
      ST_POWER_OFF: if (wake_s) st_d = ST_WAIT_PG;
      ST_WAIT_PG:   if (pg_go) st_d = ST_STABILISE;
      ST_STABILISE: if (seq_zero) st_d = ST_ISO_OFF;
      ST_ISO_OFF:   st_d = ST_READY;
      ST_READY:     st_d = ST_RUN;
      default:      st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_RUN;
      core_ratio_o <= RATIO_W'(RATIO_RST);
    end else begin
      st_q <= st_d;
      if (wake_go) core_ratio_o <= pend_ratio;
    end
  end

  assign pwr_en_o        = (st_q != ST_POWER_OFF);
  assign iso_en_o        = (st_q inside {ST_ISO_ON, ST_SELF_REF, ST_POWER_OFF,
                                         ST_WAIT_PG, ST_STABILISE});
  assign self_refresh_o  = (st_q inside {ST_SELF_REF, ST_POWER_OFF, ST_WAIT_PG,
                                         ST_STABILISE});
  assign ready_o         = (st_q == ST_RUN) || (st_q == ST_READY);
  assign pgood_timeout_o = (st_q == ST_WAIT_PG) && !use_ramp_cnt_i && tmo_zero;
endmodule

// File: rtl/pgate_seq_ctrl_chk.sv
module pgate_seq_ctrl_chk #(
  parameter int STAB_W   = 16,
  parameter int RATIO_W  = 6,
  parameter int MIN_STAB = 20000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwr_en_o,
  input logic               iso_en_o,
  input logic               self_refresh_o,
  input logic               ready_o,
  input logic [RATIO_W-1:0] core_ratio_o,
  input logic               pgood_timeout_o,
  input logic [STAB_W-1:0]  stab_q_i
);
  a_r3_off_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> (iso_en_o && self_refresh_o));

  a_r2_drop_after_prep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> ($past(iso_en_o) && $past(self_refresh_o)));

  a_r4_restore_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> (iso_en_o && self_refresh_o));

  a_r8_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (pwr_en_o && !iso_en_o && !self_refresh_o));

  a_r7_stab_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_q_i >= STAB_W'(MIN_STAB));

  a_r10_ratio_on_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_ratio_o) |-> $rose(pwr_en_o));

  a_r11_tmo_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_timeout_o |-> (pwr_en_o && iso_en_o && !ready_o));
endmodule

bind pgate_seq_ctrl pgate_seq_ctrl_chk #(
  .STAB_W(STAB_W), .RATIO_W(RATIO_W), .MIN_STAB(MIN_STAB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_o(pwr_en_o), .iso_en_o(iso_en_o),
  .self_refresh_o(self_refresh_o), .ready_o(ready_o), .core_ratio_o(core_ratio_o),
  .pgood_timeout_o(pgood_timeout_o), .stab_q_i(stab_q)
);

// File: tb/pgate_seq_ctrl_tb.sv
module pgate_seq_ctrl_tb;
  localparam int CLK_MHZ = 2, MIN_US = 4, FLOOR = CLK_MHZ * MIN_US;
  localparam int STAB_W = 6, RAMP_W = 6, TMO_W = 6, TMO = 20, RATIO_W = 4, RRST = 3;
  localparam int S_RUN = 0, S_ISO = 1, S_SR = 2, S_OFF = 3, S_WAIT = 4, S_STAB = 5,
                 S_REL = 6, S_RDY = 7;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, wake = 0, pwr_ok = 1, use_ctr = 0;
  logic [RAMP_W-1:0] ramp = 0;
  logic stab_we = 0;
  logic [STAB_W-1:0] stab_val = 0;
  logic ratio_we = 0;
  logic [RATIO_W-1:0] ratio_val = 0;
  logic pwr_en, iso_en, sref, ready, tmo;
  logic [RATIO_W-1:0] core_ratio;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  pgate_seq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .MIN_STAB_US(MIN_US), .STAB_W(STAB_W), .RAMP_W(RAMP_W),
    .TMO_W(TMO_W), .PGOOD_TMO(TMO), .RATIO_W(RATIO_W), .RATIO_RST(RRST)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_async_i(wake),
    .pwr_ok_i(pwr_ok), .use_ramp_cnt_i(use_ctr), .ramp_cycles_i(ramp),
    .stab_we_i(stab_we), .stab_cycles_i(stab_val), .ratio_we_i(ratio_we),
    .ratio_i(ratio_val), .pwr_en_o(pwr_en), .iso_en_o(iso_en),
    .self_refresh_o(sref), .ready_o(ready), .core_ratio_o(core_ratio),
    .pgood_timeout_o(tmo)
  );

  // behavioural reference
  int m_st, m_cnt, m_tmo, m_stab, m_pend, m_ratio;
  bit m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_RUN; m_cnt = 0; m_tmo = 0; m_stab = FLOOR; m_pend = RRST; m_ratio = RRST;
      m_s1 = 0; m_s2 = 0;
    end else begin
      int nst;
      bit go;
      nst = m_st;
      go = (m_st == S_WAIT) && (use_ctr ? (m_cnt == 0) : pwr_ok);
      case (m_st)
        S_RUN:  if (sleep_req) nst = S_ISO;
        S_ISO:  nst = m_s2 ? S_REL : S_SR;
        S_SR:   nst = m_s2 ? S_REL : S_OFF;
        S_OFF:  if (m_s2) nst = S_WAIT;
        S_WAIT: if (go) nst = S_STAB;
        S_STAB: if (m_cnt == 0) nst = S_REL;
        S_REL:  nst = S_RDY;
        default: nst = S_RUN;
      endcase
      if (m_st == S_OFF && m_s2) begin
        m_cnt = int'(ramp); m_tmo = TMO; m_ratio = m_pend;
      end else if (go) m_cnt = m_stab;
      else if ((m_st == S_WAIT || m_st == S_STAB) && m_cnt > 0) m_cnt--;
      if (m_st == S_WAIT && m_tmo > 0) m_tmo--;
      if (stab_we) m_stab = (int'(stab_val) < FLOOR) ? FLOOR : int'(stab_val);
      if (ratio_we) m_pend = int'(ratio_val);
      m_st = nst;
      m_s2 = m_s1; m_s1 = wake;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3 pwr_en", int'(pwr_en), int'(m_st != S_OFF));
    chk("R2 iso_en", int'(iso_en), int'(m_st >= S_ISO && m_st <= S_STAB));
    chk("R2 self_refresh", int'(sref), int'(m_st >= S_SR && m_st <= S_STAB));
    chk("R8 ready", int'(ready), int'(m_st == S_RUN || m_st == S_RDY));
    chk("R10 core_ratio", int'(core_ratio), m_ratio);
    chk("R11 timeout", int'(tmo), int'(m_st == S_WAIT && !use_ctr && m_tmo == 0));
  end

  bit tmo_seen, early_ready;

  // sleep, stay off, wake; returns cycles with supply on and isolation held
  task automatic power_cycle(input int ok_delay, output int win);
    int t;
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    t = 0;
    while (pwr_en && t < 20) begin @(negedge clk); t++; end
    pwr_ok = 0;
    repeat (4) @(negedge clk);
    wake = 1;
    t = 0;
    do begin @(negedge clk); t++; end while (!pwr_en && t < 10);
    chk("R4 wake latency", t, 3);
    wake = 0;
    win = 1; tmo_seen = 0; early_ready = 0; t = 0;
    while (!ready && t < 200) begin
      if (!use_ctr && t == ok_delay) pwr_ok = 1;
      @(negedge clk); t++;
      if (pwr_en && iso_en) win++;
      if (tmo) tmo_seen = 1;
      if (ready && !pwr_ok) early_ready = 1;
    end
    pwr_ok = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    chk("R1 pwr_en", int'(pwr_en), 1);
    chk("R1 iso_en", int'(iso_en), 0);
    chk("R1 self_refresh", int'(sref), 0);
    chk("R1 ready", int'(ready), 1);
    chk("R1 ratio", int'(core_ratio), RRST);

    // stage ratio, must not apply yet
    ratio_val = 4'd7; ratio_we = 1;
    @(negedge clk); ratio_we = 0;
    @(negedge clk);
    chk("R10 staged not applied", int'(core_ratio), RRST);

    // power-good mode
    use_ctr = 0;
    power_cycle(6, w);
    chk("R5 no ready before pwr_ok", int'(early_ready), 0);
    chk("R10 ratio applied on wake", int'(core_ratio), 7);
    chk("R11 no timeout on short wait", int'(tmo_seen), 0);

    // ramp counter mode, settling at floor (write below floor clamps)
    use_ctr = 1; ramp = 6'd3;
    stab_val = 6'd2; stab_we = 1;
    @(negedge clk); stab_we = 0;
    power_cycle(0, w);
    chk("R6 R7 window ramp3 stab clamped", w, (3 + 1) + (FLOOR + 1));

    stab_val = 6'd12; stab_we = 1;
    @(negedge clk); stab_we = 0;
    power_cycle(0, w);
    chk("R7 window stab12", w, (3 + 1) + (12 + 1));

    ramp = 6'd0;
    power_cycle(0, w);
    chk("R6 window ramp0", w, 1 + (12 + 1));

    // aborted shutdown
    begin
      bit dropped, sr_seen;
      int t;
      ratio_val = 4'd9; ratio_we = 1;
      @(negedge clk); ratio_we = 0;
      sleep_req = 1; wake = 1;
      @(negedge clk); sleep_req = 0;
      dropped = 0; sr_seen = 0; t = 0;
      while (!ready && t < 20) begin
        @(negedge clk); t++;
        if (!pwr_en) dropped = 1;
        if (sref) sr_seen = 1;
      end
      wake = 0;
      chk("R9 supply never dropped", int'(dropped), 0);
      chk("R9 self-refresh entered then left", int'(sr_seen), 1);
      chk("R9 back to ready", int'(ready), 1);
      chk("R10 ratio kept on abort", int'(core_ratio), 7);
      repeat (4) @(negedge clk);
    end

    // power-good timeout
    use_ctr = 0;
    power_cycle(30, w);
    chk("R11 timeout raised", int'(tmo_seen), 1);
    chk("R11 timeout cleared", int'(tmo), 0);
    chk("R10 second staged ratio applied", int'(core_ratio), 9);

    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule